// File: doc/BRIEF.md
# Dual-Frequency Pulse Burst Generator

This block drives a single pulse line with a burst made of three parts. First comes a train of pulses at one programmable frequency. A train at a second frequency follows. The burst closes with one stop pulse of opposite polarity. Each train has its own period, its own active time and its own number of whole periods. The stop pulse has a programmable length and an enable. A one-cycle start strobe launches the burst. A stop strobe cuts the trains short.

The configuration arrives as plain parallel inputs. The block takes a private copy of it when a start is accepted, so the surrounding system may rewrite its registers freely while a burst runs. A finite-state machine steps through five states: IDLE (0), FIRST (1), SECOND (2), STOPPULSE (3) and DONE (4). The current code is visible on `state_o`, and `busy_o` tells software whether a burst is in progress.

The state machine has the following transitions:
- IDLE→FIRST, IDLE→SECOND, IDLE→STOPPULSE or IDLE→DONE, on an accepted start, to the first part that is not skipped.
- FIRST→SECOND and FIRST/SECOND→STOPPULSE or →DONE, when a train completes its last period.
- FIRST/SECOND→STOPPULSE or →IDLE, on a stop strobe.
- STOPPULSE→DONE, when the stop pulse ends.
- DONE→IDLE, always.

Top module: `pulse_burst_gen`

## Requirements
- R1: After reset, and whenever the state is IDLE, `state_o` is 0 and `pulse_o` and `busy_o` are low.
- R2: A start strobe sampled in IDLE moves the block on the next clock edge into the first part not skipped. The parts are checked in the order FIRST (code 1), SECOND (code 2), STOPPULSE (code 3). If all three are skipped, the block moves to DONE (code 4).
- R3: Within a train, each period lasts P cycles, where a programmed period of 0 counts as 1. `pulse_o` is low for the first A cycles of the period and high for the rest. An active time of P or more keeps the line low for the whole period.
- R4: A train runs for exactly N whole periods. A count N of 0 skips that train.
- R5: The parts run in the order FIRST, SECOND, STOPPULSE, DONE. DONE lasts exactly one cycle with `pulse_o` low, and the block then returns to IDLE.
- R6: When the stop pulse is enabled and its length S is nonzero, STOPPULSE drives `pulse_o` high for exactly S cycles. Otherwise STOPPULSE is skipped.
- R7: A stop strobe sampled in FIRST or SECOND moves the block on the next edge to STOPPULSE if the stop pulse is in use (R6), and to IDLE otherwise.
- R8: A stop strobe in IDLE, STOPPULSE or DONE has no effect.
- R9: A start strobe while `busy_o` is high has no effect.
- R10: All configuration is captured when a start is accepted. Changes to the configuration inputs during a burst do not alter it.
- R11: `busy_o` is high in every state except IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop strobe |
| a_period_i | input | CNT_W | First train period in cycles |
| a_active_i | input | CNT_W | First train low (active) cycles per period |
| a_count_i | input | NUM_W | First train number of periods |
| b_period_i | input | CNT_W | Second train period in cycles |
| b_active_i | input | CNT_W | Second train low (active) cycles per period |
| b_count_i | input | NUM_W | Second train number of periods |
| stop_len_i | input | SLEN_W | Stop pulse length in cycles |
| stop_en_i | input | 1 | Stop pulse enable |
| pulse_o | output | 1 | Pulse line |
| busy_o | output | 1 | Burst in progress |
| state_o | output | 3 | Current state code |

## Verification
The bench targets the following corner cases, each paired with what a faulty design would show:
- A period of zero, and an active time at or beyond the period. A design that mishandled these would stall its period counter, or emit a spurious high cycle.
- Trains with a count of zero, and a stop pulse of length zero or disabled. A design that failed to skip them would emit an extra period or linger in a state.
- Stop strobes held high from inside a train through the stop pulse and into IDLE. These expose a design that restarts or truncates the stop pulse, or that jumps to STOPPULSE when the stop pulse is disabled.
- Start strobes and fresh configuration values thrown at a running burst. These expose a design that restarts, or that reads its live inputs instead of its captured copy.

// File: rtl/pbg_pkg.sv
`timescale 1ns/1ps
package pbg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FIRST  = 3'd1,
        ST_SECOND = 3'd2,
        ST_STOP   = 3'd3,
        ST_DONE   = 3'd4
    } pbg_state_e;
endpackage

// File: rtl/pbg_cfg_latch.sv
`timescale 1ns/1ps
module pbg_cfg_latch #(
    parameter int CNT_W  = 8,
    parameter int NUM_W  = 8,
    parameter int SLEN_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              capture_i,
    input  logic [CNT_W-1:0]  a_period_i,
    input  logic [CNT_W-1:0]  a_active_i,
    input  logic [NUM_W-1:0]  a_count_i,
    input  logic [CNT_W-1:0]  b_period_i,
    input  logic [CNT_W-1:0]  b_active_i,
    input  logic [NUM_W-1:0]  b_count_i,
    input  logic [SLEN_W-1:0] stop_len_i,
    input  logic              stop_en_i,
    output logic [CNT_W-1:0]  a_period_o,
    output logic [CNT_W-1:0]  a_active_o,
    output logic [NUM_W-1:0]  a_count_o,
    output logic [CNT_W-1:0]  b_period_o,
    output logic [CNT_W-1:0]  b_active_o,
    output logic [NUM_W-1:0]  b_count_o,
    output logic [SLEN_W-1:0] stop_len_o,
    output logic              stop_en_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            a_period_o <= '0;
            a_active_o <= '0;
            a_count_o  <= '0;
            b_period_o <= '0;
            b_active_o <= '0;
            b_count_o  <= '0;
            stop_len_o <= '0;
            stop_en_o  <= 1'b0;
        end else if (capture_i) begin
            a_period_o <= a_period_i;
            a_active_o <= a_active_i;
            a_count_o  <= a_count_i;
            b_period_o <= b_period_i;
            b_active_o <= b_active_i;
            b_count_o  <= b_count_i;
            stop_len_o <= stop_len_i;
            stop_en_o  <= stop_en_i;
        end
    end

    // R10: captured copy only moves on an accepted start
    a_r10_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !capture_i |=> ($stable(a_period_o) && $stable(a_active_o) && $stable(a_count_o)
                        && $stable(b_period_o) && $stable(b_active_o) && $stable(b_count_o)
                        && $stable(stop_len_o) && $stable(stop_en_o)));
endmodule

// File: rtl/pbg_phase_ctr.sv
`timescale 1ns/1ps
module pbg_phase_ctr #(
    parameter int CNT_W = 8,
    parameter int NUM_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] active_i,
    input  logic [NUM_W-1:0] count_i,
    output logic             low_o,
    output logic             last_o
);
    logic [CNT_W-1:0] cyc_q;
    logic [NUM_W-1:0] num_q;
    logic [CNT_W-1:0] period_eff;
    logic             wrap;

    assign period_eff = (period_i == '0) ? CNT_W'(1) : period_i;
    assign wrap       = (cyc_q == period_eff - CNT_W'(1));
    assign low_o      = (cyc_q < active_i);
    assign last_o     = run_i && wrap && (num_q == count_i - NUM_W'(1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cyc_q <= '0;
            num_q <= '0;
        end else if (clear_i) begin
            cyc_q <= '0;
            num_q <= '0;
        end else if (run_i) begin
            if (wrap) begin
                cyc_q <= '0;
                num_q <= num_q + NUM_W'(1);
            end else begin
                cyc_q <= cyc_q + CNT_W'(1);
            end
        end
    end

    // R3: the cycle index never leaves the current period
    a_r3_cyc_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (cyc_q < period_eff));
    // R4: no train runs past its programmed period count
    a_r4_num_in_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (num_q < count_i));
endmodule

// File: rtl/pbg_stop_ctr.sv
`timescale 1ns/1ps
module pbg_stop_ctr #(
    parameter int SLEN_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic              run_i,
    input  logic [SLEN_W-1:0] len_i,
    output logic              last_o
);
    logic [SLEN_W-1:0] cnt_q;

    assign last_o = run_i && (cnt_q == len_i - SLEN_W'(1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else if (run_i)   cnt_q <= cnt_q + SLEN_W'(1);
    end

    // R6: the stop pulse never outlasts its length
    a_r6_stop_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (cnt_q < len_i));
endmodule

// File: rtl/pulse_burst_gen.sv
`timescale 1ns/1ps
module pulse_burst_gen
    import pbg_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int NUM_W  = 8,
    parameter int SLEN_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [CNT_W-1:0]  a_period_i,
    input  logic [CNT_W-1:0]  a_active_i,
    input  logic [NUM_W-1:0]  a_count_i,
    input  logic [CNT_W-1:0]  b_period_i,
    input  logic [CNT_W-1:0]  b_active_i,
    input  logic [NUM_W-1:0]  b_count_i,
    input  logic [SLEN_W-1:0] stop_len_i,
    input  logic              stop_en_i,
    output logic              pulse_o,
    output logic              busy_o,
    output logic [2:0]        state_o
);
    pbg_state_e state_q, state_d;

    logic [CNT_W-1:0]  a_per_q, a_act_q, b_per_q, b_act_q;
    logic [NUM_W-1:0]  a_cnt_q, b_cnt_q;
    logic [SLEN_W-1:0] slen_q;
    logic              sen_q;
    logic              accept, in_train, ph_low, ph_last, sp_last, clear;
    logic              stop_use_q, stop_use_in;

    assign accept      = (state_q == ST_IDLE) && start_i;
    assign in_train    = (state_q == ST_FIRST) || (state_q == ST_SECOND);
    assign stop_use_q  = sen_q && (slen_q != '0);
    assign stop_use_in = stop_en_i && (stop_len_i != '0);
    assign clear       = (state_d != state_q);

    pbg_cfg_latch #(.CNT_W(CNT_W), .NUM_W(NUM_W), .SLEN_W(SLEN_W)) u_cfg (
        .clk_i, .rst_ni,
        .capture_i (accept),
        .a_period_i, .a_active_i, .a_count_i,
        .b_period_i, .b_active_i, .b_count_i,
        .stop_len_i, .stop_en_i,
        .a_period_o (a_per_q), .a_active_o (a_act_q), .a_count_o (a_cnt_q),
        .b_period_o (b_per_q), .b_active_o (b_act_q), .b_count_o (b_cnt_q),
        .stop_len_o (slen_q),  .stop_en_o  (sen_q)
    );

    pbg_phase_ctr #(.CNT_W(CNT_W), .NUM_W(NUM_W)) u_phase (
        .clk_i, .rst_ni,
        .clear_i  (clear),
        .run_i    (in_train),
        .period_i ((state_q == ST_SECOND) ? b_per_q : a_per_q),
        .active_i ((state_q == ST_SECOND) ? b_act_q : a_act_q),
        .count_i  ((state_q == ST_SECOND) ? b_cnt_q : a_cnt_q),
        .low_o    (ph_low),
        .last_o   (ph_last)
    );

    pbg_stop_ctr #(.SLEN_W(SLEN_W)) u_stop (
        .clk_i, .rst_ni,
        .clear_i (clear),
        .run_i   (state_q == ST_STOP),
        .len_i   (slen_q),
        .last_o  (sp_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (a_count_i != '0)      state_d = ST_FIRST;
                    else if (b_count_i != '0) state_d = ST_SECOND;
                    else if (stop_use_in)     state_d = ST_STOP;
                    else                      state_d = ST_DONE;
                end
            end
            ST_FIRST: begin
                if (stop_i)                state_d = stop_use_q ? ST_STOP : ST_IDLE;
                else if (ph_last) begin
                    if (b_cnt_q != '0)     state_d = ST_SECOND;
                    else                   state_d = stop_use_q ? ST_STOP : ST_DONE;
                end
            end
            ST_SECOND: begin
                if (stop_i)                state_d = stop_use_q ? ST_STOP : ST_IDLE;
                else if (ph_last)          state_d = stop_use_q ? ST_STOP : ST_DONE;
            end
            ST_STOP: begin
                if (sp_last)               state_d = ST_DONE;
            end
            ST_DONE:                       state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // outputs
    always_comb begin
        pulse_o = 1'b0;
        busy_o  = 1'b1;
        unique case (state_q)
            ST_IDLE:   busy_o  = 1'b0;
            ST_FIRST,
            ST_SECOND: pulse_o = !ph_low;
            ST_STOP:   pulse_o = 1'b1;
            ST_DONE:   pulse_o = 1'b0;
            default:   busy_o  = 1'b0;
        endcase
    end
    assign state_o = state_q;

    // R1: IDLE rests low and not busy
    a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd0) |-> (!pulse_o && !busy_o));
    // R2: only the five defined codes appear
    a_r2_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o <= 3'd4);
    // R5: DONE lasts one cycle
    a_r5_done_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd4) |=> (state_o == 3'd0));
    // R7: stop strobe with stop pulse unused returns to IDLE
    a_r7_stop_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_train && stop_i && !stop_use_q) |=> (state_o == 3'd0));
    // R8: stop strobe inside the stop pulse is ignored
    a_r8_stop_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_STOP && stop_i && !sp_last) |=> (state_o == 3'd3));
    // R9: a start while busy in a train does not restart it
    a_r9_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SECOND && start_i && !stop_i && !ph_last) |=> (state_o == 3'd2));
    // R11: busy tracks any state other than IDLE
    a_r11_busy_states: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o != 3'd0) |-> busy_o);
endmodule

// File: tb/pulse_burst_gen_tb.sv
`timescale 1ns/1ps
module pulse_burst_gen_tb;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0;
    logic [7:0] a_period_i = '0, a_active_i = '0, a_count_i = '0;
    logic [7:0] b_period_i = '0, b_active_i = '0, b_count_i = '0;
    logic [7:0] stop_len_i = '0;
    logic       stop_en_i = 1'b0;
    logic       pulse_o, busy_o;
    logic [2:0] state_o;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #5 clk_i = ~clk_i;

    pulse_burst_gen u_dut (
        .clk_i, .rst_ni, .start_i, .stop_i,
        .a_period_i, .a_active_i, .a_count_i,
        .b_period_i, .b_active_i, .b_count_i,
        .stop_len_i, .stop_en_i,
        .pulse_o, .busy_o, .state_o
    );

    // burst configuration as seen by the model
    int p1, a1, n1, p2, a2, n2, sl;
    bit se;

    function automatic int peff(int p);
        return (p == 0) ? 1 : p;
    endfunction

    // expected {state,pulse} at cycle t after start, stop strobe first sampled at t=stop_at
    function automatic logic [3:0] model(int t, int stop_at);
        int t1, t2, ts, k;
        bit use_stop;
        use_stop = se && (sl != 0);
        t1 = n1 * peff(p1);
        t2 = n2 * peff(p2);
        ts = use_stop ? sl : 0;
        if (stop_at >= 0 && t > stop_at) begin
            k = t - stop_at - 1;
            if (!use_stop) return {3'd0, 1'b0};
            if (k < sl)  return {3'd3, 1'b1};
            if (k == sl) return {3'd4, 1'b0};
            return {3'd0, 1'b0};
        end
        if (t < t1)           return {3'd1, ((t % peff(p1)) >= a1)};
        if (t < t1 + t2)      return {3'd2, (((t - t1) % peff(p2)) >= a2)};
        if (t < t1 + t2 + ts) return {3'd3, 1'b1};
        if (t == t1 + t2 + ts) return {3'd4, 1'b0};
        return {3'd0, 1'b0};
    endfunction

    function automatic int burst_len();
        return n1 * peff(p1) + n2 * peff(p2) + ((se && sl != 0) ? sl : 0) + 1;
    endfunction

    task automatic check_now(string tag, int t, logic [3:0] exp);
        checks++;
        if (state_o !== exp[3:1] || pulse_o !== exp[0] || busy_o !== (exp[3:1] != 3'd0)) begin
            errors++;
            $display("FAIL %s t=%0d: state/pulse/busy actual %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, t, state_o, pulse_o, busy_o, exp[3:1], exp[0], (exp[3:1] != 3'd0));
        end
    endtask

    // run one burst; stop_at<0 means no stop strobe; noisy toggles start and config mid-burst
    task automatic run_burst(string tag, int stop_at, bit noisy);
        int len;
        @(negedge clk_i);
        a_period_i = 8'(p1); a_active_i = 8'(a1); a_count_i = 8'(n1);
        b_period_i = 8'(p2); b_active_i = 8'(a2); b_count_i = 8'(n2);
        stop_len_i = 8'(sl); stop_en_i = se;
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        len = burst_len();
        for (int t = 0; t <= len + 1; t++) begin
            check_now(tag, t, model(t, stop_at));
            stop_i = (stop_at >= 0 && t >= stop_at && t < len);
            if (noisy && t < len - 2) begin
                start_i    = 1'($urandom_range(0, 1));
                a_period_i = 8'($urandom); a_active_i = 8'($urandom); a_count_i = 8'($urandom);
                b_period_i = 8'($urandom); b_active_i = 8'($urandom); b_count_i = 8'($urandom);
                stop_len_i = 8'($urandom); stop_en_i  = 1'($urandom);
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk_i);
            if (stop_at >= 0 && t >= stop_at && model(t + 1, stop_at) == 4'b0000) break;
        end
        start_i = 1'b0;
        stop_i  = 1'b0;
    endtask

    task automatic set_cfg(int xp1, int xa1, int xn1, int xp2, int xa2, int xn2, int xsl, bit xse);
        p1 = xp1; a1 = xa1; n1 = xn1; p2 = xp2; a2 = xa2; n2 = xn2; sl = xsl; se = xse;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk_i);
        // R1: reset state
        check_now("R1", -1, {3'd0, 1'b0});
        rst_ni = 1'b1;
        @(negedge clk_i);
        check_now("R1", -1, {3'd0, 1'b0});

        // R8: stop strobe in IDLE ignored
        stop_i = 1'b1;
        @(negedge clk_i);
        stop_i = 1'b0;
        check_now("R8", -1, {3'd0, 1'b0});

        // R2/R3/R4/R5/R6: directed full burst
        set_cfg(4, 1, 2, 3, 2, 3, 3, 1);
        run_burst("R5", -1, 0);
        // R3: zero period and active >= period
        set_cfg(0, 0, 3, 2, 5, 2, 1, 1);
        run_burst("R3", -1, 0);
        // R4/R2: first train skipped, second only
        set_cfg(5, 2, 0, 3, 1, 2, 0, 1);
        run_burst("R4", -1, 0);
        // R2: everything skipped, straight to DONE
        set_cfg(3, 1, 0, 3, 1, 0, 4, 0);
        run_burst("R2", -1, 0);
        // R6: stop pulse alone
        set_cfg(3, 1, 0, 3, 1, 0, 4, 1);
        run_burst("R6", -1, 0);
        // R7: stop in first train with stop pulse used, strobe held (R8)
        set_cfg(4, 2, 3, 2, 1, 2, 3, 1);
        run_burst("R7", 5, 0);
        // R7: stop in second train with stop pulse disabled
        set_cfg(2, 1, 1, 3, 1, 3, 3, 0);
        run_burst("R7", 4, 0);
        // R9/R10: start and config noise during a burst
        set_cfg(3, 1, 2, 4, 3, 2, 2, 1);
        run_burst("R10", -1, 1);

        // constrained random bursts
        for (int i = 0; i < 40; i++) begin
            int sa;
            set_cfg($urandom_range(0, 6), $urandom_range(0, 7), $urandom_range(0, 3),
                    $urandom_range(0, 6), $urandom_range(0, 7), $urandom_range(0, 3),
                    $urandom_range(0, 4), 1'($urandom_range(0, 1)));
            sa = -1;
            if ((i % 4) == 3 && (n1 * peff(p1) + n2 * peff(p2)) > 0)
                sa = $urandom_range(0, n1 * peff(p1) + n2 * peff(p2) - 1);
            run_burst((sa >= 0) ? "R7" : "R9", sa, 1'(i % 2));
        end

        // R11: back at rest
        @(negedge clk_i);
        check_now("R11", -1, {3'd0, 1'b0});

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule